// File: doc/BRIEF.md
# Sequential Integer Divider with Four Size/Sign Modes

This unit divides a 32-bit or 16-bit dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder. It works with signed or unsigned operands. A 2-bit mode input selects one of four combinations. The upper and lower halves of the dividend arrive on separate 16-bit inputs. In the two short modes the upper input is ignored, and the upper half is formed from the lower word instead.

A caller raises `start` for one cycle while the unit is idle, and the operands are captured on that edge. The unit first converts both operands to their magnitudes. It then runs one restoring step per divisor bit, so each step retires one quotient bit. A final cycle applies the result signs and registers the outputs. Both dividend sizes take the same time. The caller waits for the one-cycle `done` pulse and reads the results, which stay held until the next operation completes. Two flags report a zero divisor and a quotient that does not fit in 16 bits.

Top module: `seq_divider`

## Requirements
- R1: `mode` selects the operation. Bit 1 set means a 16-bit dividend and clear means 32-bit. Bit 0 set means unsigned and clear means signed (00 = 32s, 01 = 32u, 10 = 16s, 11 = 16u). In unsigned 32-bit mode, `quo` and `rem` equal the integer quotient and remainder of {dvd_hi,dvd_lo} / dvs.
- R2: In the signed modes the quotient truncates toward zero. The remainder has the sign of the dividend, and quotient*divisor + remainder equals the dividend.
- R3: In the 16-bit modes `dvd_hi` has no effect. The upper half is the sign extension of `dvd_lo` in signed mode and zeros in unsigned mode.
- R4: After the edge that accepts `start`, `busy` is high for exactly 17 cycles (16 iteration cycles plus one sign cycle). `done` is then high for exactly one cycle with `busy` low. This holds for every mode.
- R5: `start` is accepted only while `busy` is low. A `start` raised during an operation neither changes its results nor its timing.
- R6: A zero divisor sets `div_zero` and clears `overflow` in the `done` cycle. A nonzero divisor clears `div_zero`.
- R7: With a nonzero divisor, `overflow` is set exactly when the true quotient falls outside 0..65535 (unsigned) or -32768..32767 (signed). When `overflow` is set, `quo` and `rem` carry no meaning.
- R8: `quo`, `rem`, `div_zero` and `overflow` change only at the edge that raises `done`, and they hold their values between operations.
- R9: While reset is active, and after its release, `busy`, `done`, `quo`, `rem`, `div_zero` and `overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| mode | input | 2 | Bit 1: 16-bit dividend; bit 0: unsigned |
| dvd_hi | input | 16 | Upper dividend word (32-bit modes only) |
| dvd_lo | input | 16 | Lower dividend word |
| dvs | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; results valid |
| quo | output | 16 | Quotient |
| rem | output | 16 | Remainder |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient does not fit in 16 bits |

## Verification
The bench raises `start` at a falling edge, so the rising edge that follows is the accepting edge. From that edge, the bench expects `busy` high at each of the next 17 falling edges and `done` high with new results at the 18th. It samples every output at exactly those falling edges and reports a `done` that comes early or late. Results are then rechecked a few cycles later, after the inputs have changed with `start` low, to confirm they are held. Some operations are also hit with a second `start` in mid-flight, and their results and timing must stay those of the first operands.

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvs,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         div_zero,
  output logic         overflow
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic          short_m, sgn_m, dvd_neg, dvs_neg, pre_ovf;
  logic [W-1:0]  hi_ext, mag_dvs;
  logic [DW-1:0] full, mag_dvd;

  assign short_m = mode[1];
  assign sgn_m   = ~mode[0];
  assign hi_ext  = short_m ? (sgn_m ? {W{dvd_lo[W-1]}} : '0) : dvd_hi;
  assign full    = {hi_ext, dvd_lo};
  assign dvd_neg = sgn_m & full[DW-1];
  assign dvs_neg = sgn_m & dvs[W-1];
  assign mag_dvd = dvd_neg ? -full : full;
  assign mag_dvs = dvs_neg ? -dvs : dvs;
  assign pre_ovf = mag_dvd[DW-1:W] >= mag_dvs;

  logic [CW-1:0] cnt;
  logic [W-1:0]  r_r, r_q, r_d;
  logic          neg_q, neg_r, sgn_r, povf_r, dz_r;
  logic [W:0]    trial;
  logic          range_ovf;

  assign trial     = {r_r, r_q[W-1]} - {1'b0, r_d};
  assign range_ovf = sgn_r & (neg_q ? (r_q > HALF) : r_q[W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      quo      <= '0;
      rem      <= '0;
      div_zero <= 1'b0;
      overflow <= 1'b0;
      cnt      <= '0;
      r_r      <= '0;
      r_q      <= '0;
      r_d      <= '0;
      neg_q    <= 1'b0;
      neg_r    <= 1'b0;
      sgn_r    <= 1'b0;
      povf_r   <= 1'b0;
      dz_r     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          r_r    <= mag_dvd[DW-1:W];
          r_q    <= mag_dvd[W-1:0];
          r_d    <= mag_dvs;
          neg_q  <= dvd_neg ^ dvs_neg;
          neg_r  <= dvd_neg;
          sgn_r  <= sgn_m;
          povf_r <= pre_ovf;
          dz_r   <= (dvs == '0);
        end
      end else if (cnt != LAST) begin
        cnt <= cnt + 1'b1;
        if (!trial[W]) begin
          r_r <= trial[W-1:0];
          r_q <= {r_q[W-2:0], 1'b1};
        end else begin
          r_r <= {r_r[W-2:0], r_q[W-1]};
          r_q <= {r_q[W-2:0], 1'b0};
        end
      end else begin
        busy     <= 1'b0;
        done     <= 1'b1;
        quo      <= neg_q ? -r_q : r_q;
        rem      <= neg_r ? -r_r : r_r;
        div_zero <= dz_r;
        overflow <= ~dz_r & (povf_r | range_ovf);
      end
    end
  end
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   mode,
  input logic [W-1:0] dvd_hi,
  input logic [W-1:0] dvd_lo,
  input logic [W-1:0] dvs,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quo,
  input logic [W-1:0] rem,
  input logic         div_zero,
  input logic         overflow
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(W + 3);

  logic [CW-1:0] bcnt;
  logic [1:0]    l_mode;
  logic [W-1:0]  l_hi, l_lo, l_dvs;
  logic [DW-1:0] l_dvd, recon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0; l_mode <= '0; l_hi <= '0; l_lo <= '0; l_dvs <= '0;
    end else if (start && !busy) begin
      bcnt <= '0; l_mode <= mode; l_hi <= dvd_hi; l_lo <= dvd_lo; l_dvs <= dvs;
    end else if (busy) begin
      bcnt <= bcnt + 1'b1;
    end
  end

  assign l_dvd = l_mode[1] ? {{W{1'b0}}, l_lo} : {l_hi, l_lo};
  assign recon = DW'(quo) * DW'(l_dvs) + DW'(rem);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                              // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                              // R4
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bcnt == CW'(W + 1));                                 // R4
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);                                   // R5
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_zero == (l_dvs == '0)) && !(div_zero && overflow)); // R6
  AST_UNSIGNED_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && l_mode[0] && !div_zero && !overflow) |-> recon == l_dvd); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(quo) && $stable(rem) && $stable(div_zero) && $stable(overflow)); // R8
endmodule

bind seq_divider seq_divider_chk #(.W(W)) u_chk (.*);

// File: tb/test_seq_divider.sv
module test_seq_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [15:0] dvd_hi = '0, dvd_lo = '0, dvs = '0;
  logic        busy, done, div_zero, overflow;
  logic [15:0] quo, rem;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  seq_divider i_seq_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
    .busy(busy), .done(done), .quo(quo), .rem(rem),
    .div_zero(div_zero), .overflow(overflow)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic        e_dz, e_ovf;
  logic [15:0] e_q, e_r;

  function automatic void model(input logic [1:0] m, input logic [15:0] h,
                                input logic [15:0] l, input logic [15:0] d);
    longint a, b, q, r;
    if (m[1]) a = m[0] ? longint'(l) : longint'($signed(l));
    else      a = m[0] ? longint'({h, l}) : longint'($signed({h, l}));
    b = m[0] ? longint'(d) : longint'($signed(d));
    e_dz = (d == 16'h0); e_ovf = 1'b0; e_q = '0; e_r = '0;
    if (!e_dz) begin
      q = a / b; r = a % b;
      e_ovf = m[0] ? (q > 65535) : (q > 32767 || q < -32768);
      e_q = q[15:0]; e_r = r[15:0];
    end
  endfunction

  task automatic run(input logic [1:0] m, input logic [15:0] h, input logic [15:0] l,
                     input logic [15:0] d, input bit poke, input string req);
    model(m, h, l, d);
    @(negedge clk);
    mode = m; dvd_hi = h; dvd_lo = l; dvs = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 17; i++) begin
      if (poke && i == 5) begin
        start = 1'b1; dvs = ~d; dvd_lo = ~l; mode = ~m;
      end
      if (poke && i == 6) start = 1'b0;
      if (!busy || done) chk({req, " R4 busy window"}, {busy, done}, 2'b10);
      if (i < 17) @(negedge clk);
    end
    @(negedge clk);
    chk({req, " R4 done pulse"}, {busy, done}, 2'b01);
    chk({req, " R6 div_zero"}, div_zero, e_dz);
    chk({req, " R7 overflow"}, overflow, e_ovf);
    if (!e_dz && !e_ovf) begin
      chk({req, " quotient"}, quo, e_q);
      chk({req, " remainder"}, rem, e_r);
    end
    dvd_hi = ~h; dvd_lo = l ^ 16'h5a5a; dvs = d + 16'd3; mode = m ^ 2'b01;
    repeat (3) @(negedge clk);
    chk({req, " R8 done low"}, done, 1'b0);
    if (!e_dz && !e_ovf) begin
      chk({req, " R8 quo held"}, quo, e_q);
      chk({req, " R8 rem held"}, rem, e_r);
    end
    chk({req, " R8 flags held"}, {div_zero, overflow}, {e_dz, e_ovf});
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {busy, done, div_zero, overflow, quo, rem}, 36'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after release", {busy, done, div_zero, overflow, quo, rem}, 36'h0);

    run(2'b01, 16'h0001, 16'h0000, 16'h0002, 0, "R1 32u basic");
    run(2'b01, 16'hfffe, 16'hffff, 16'hffff, 0, "R1 32u max");
    run(2'b01, 16'h0003, 16'h0000, 16'h0003, 0, "R7 32u hi==dvs");
    run(2'b00, 16'hffff, 16'hfff9, 16'h0002, 0, "R2 -7/2");
    run(2'b00, 16'h0000, 16'h0007, 16'hfffe, 0, "R2 7/-2");
    run(2'b00, 16'hffff, 16'hfff9, 16'hfffe, 0, "R2 -7/-2");
    run(2'b00, 16'hffff, 16'h8000, 16'h0001, 0, "R7 32s min quotient");
    run(2'b00, 16'h0000, 16'h8000, 16'h0001, 0, "R7 32s +32768");
    run(2'b00, 16'h8000, 16'h0000, 16'hffff, 0, "R7 32s most negative");
    run(2'b10, 16'h1234, 16'h8000, 16'hffff, 0, "R7 16s -32768/-1");
    run(2'b10, 16'h7777, 16'hfff1, 16'h0004, 0, "R3 16s sign extend");
    run(2'b11, 16'hffff, 16'hfff1, 16'h0004, 0, "R3 16u zero extend");
    run(2'b11, 16'h0000, 16'hffff, 16'h0001, 0, "R3 16u max");
    run(2'b01, 16'h0005, 16'h0000, 16'h0000, 0, "R6 zero divisor 32u");
    run(2'b10, 16'h0000, 16'h8000, 16'h0000, 0, "R6 zero divisor 16s");
    run(2'b01, 16'h0010, 16'h2345, 16'h1000, 1, "R5 start while busy");
    run(2'b00, 16'hfff0, 16'h0000, 16'h7000, 1, "R5 start while busy signed");

    for (int n = 0; n < 300; n++) begin
      logic [1:0]  m;
      logic [15:0] h, l, d;
      m = 2'($urandom % 4);
      l = 16'($urandom);
      d = 16'($urandom);
      case ($urandom % 4)
        0: h = 16'($urandom);
        1: h = 16'($urandom % 8);
        2: h = 16'hffff - 16'($urandom % 8);
        default: h = d >> 1;
      endcase
      if (($urandom % 16) == 0) d = 16'h0;
      if (($urandom % 8) == 0) d = 16'($urandom % 5);
      run(m, h, l, d, (n % 7) == 3, m[1] ? "R3 random" : (m[0] ? "R1 random" : "R2 random"));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule